// File: doc/BRIEF.md
# Dynamic Bus Sizing Controller

This controller sits between a processor core and an asynchronous 32-bit external bus. The core hands it one operand of 1 to 4 bytes at any byte address, either to store or to fetch. The controller breaks the operand into as many bus cycles as the responding device needs. In every cycle the device reports its own port width (8, 16 or 32 bits) on a two-bit acknowledge. The controller uses that width, the two low address bits and the byte count still owed to decide how far to advance.

Memory is big-endian. Byte lane 0 is bits 31:24 of the data bus and carries the byte whose address ends in 00. An 8-bit device is wired to lane 0 only, and a 16-bit device to lanes 0 and 1. On a store, the controller places each outgoing byte on every lane where a device of any width could pick it up. On a fetch, it collects the returned bytes into an assembly register and presents the operand right-justified. A bus error abandons the rest of the operand.

Top module: `dbsz_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `busy`, `done`, `err`, `bus_as`, `bus_ds`, `bus_ecs`, `bus_ocs` and `bus_rmw` are all low.
- R2: At the start of each bus cycle, `bus_siz` gives the bytes still owed for the operand, encoded 01=1, 10=2, 11=3 and 00=4. Address and size stay stable for the whole cycle.
- R3: `bus_ecs` is high for exactly one clock at the start of every bus cycle. `bus_ocs` is high in that same clock, and only in the first cycle of an operand.
- R4: `bus_as` and `bus_ds` rise together with `bus_ecs`. They stay high until the clock edge that samples a terminating `bus_ack` or `bus_berr`, and are low in the clock after it.
- R5: The acknowledge codes are 00=wait, 01=8-bit port, 10=16-bit port and 11=32-bit port. Each terminated cycle moves this many bytes: 1 on an 8-bit port; min(remaining, 2 - addr[0]) on a 16-bit port; min(remaining, 4 - addr[1:0]) on a 32-bit port. The next cycle's address is the old address plus the bytes moved. `bus_rd` is 1 for a fetch and 0 for a store.
- R6: On a store, lane 0 carries the next outgoing byte. Lane 1 carries that byte when addr[0]=1, and otherwise the byte after it. Lanes 2 and 3 carry the byte that belongs at their own address within the aligned word. As a result, an 8-bit, 16-bit or 32-bit device each stores the correct operand bytes.
- R7: On a fetch, the bytes taken from the lanes of the responding port are assembled in address order. The operand appears right-justified on `rdata` in the clock where `done` is high.
- R8: `done` pulses for one clock, one clock after the edge that terminates the last bus cycle. `busy` is low in that clock, and `done` and `err` are never high together.
- R9: `bus_berr` sampled high during a cycle ends it. `err` then pulses one clock later, no `done` follows, no further bus cycle of that operand starts, and the bytes not yet stored stay untouched.
- R10: `bus_rmw` rises when a locked request starts. It stays high through every cycle and every idle clock in between, and falls after a locked store completes or after a bus error.
- R11: While `bus_ack` is 00 and `bus_berr` is low, the cycle is extended: `bus_as` and `bus_ds` stay high and no new cycle starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Start an operand transfer (taken only when idle) |
| req_write | input | 1 | 1 = store, 0 = fetch |
| req_lock | input | 1 | Operand belongs to an indivisible read-modify-write pair |
| req_addr | input | ADDR_W | Byte address of the first operand byte |
| req_len | input | 3 | Operand length in bytes, 1 to 4 |
| req_wdata | input | 32 | Store operand, right-justified, first byte most significant |
| busy | output | 1 | An operand is in progress |
| done | output | 1 | One-clock pulse: operand completed |
| err | output | 1 | One-clock pulse: operand ended by bus error |
| rdata | output | 32 | Fetched operand, right-justified, valid with done |
| bus_addr | output | ADDR_W | Bus address of the current cycle |
| bus_siz | output | 2 | Bytes still owed at the cycle start |
| bus_rd | output | 1 | 1 = read cycle, 0 = write cycle |
| bus_ecs | output | 1 | Pulse at the start of every bus cycle |
| bus_ocs | output | 1 | Pulse at the start of an operand's first cycle |
| bus_as | output | 1 | Address valid |
| bus_ds | output | 1 | Data strobe |
| bus_rmw | output | 1 | Indivisible sequence in progress |
| bus_dout | output | 32 | Store data with lane replication |
| bus_dout_en | output | 1 | Controller drives the data bus |
| bus_din | input | 32 | Fetch data from the device |
| bus_ack | input | 2 | Termination and port width, 00 = wait |
| bus_berr | input | 1 | Bus error termination |

## Verification
- Cycle start: a request sampled at one rising edge produces `bus_ecs`, `bus_as` and the first address in the clock that follows.
- Cycle end: a terminating acknowledge sampled at a rising edge drops the strobes after that same edge. In the same clock it raises `done` or `err` if the operand is finished; otherwise the next cycle's `bus_ecs` appears one clock after that.
- Bench sampling: the responder model and the completion monitor both look on the falling edge, half a clock after each of those register updates. The responder places its acknowledge on a falling edge so that exactly one rising edge samples it.
- Expected values: address, size and operand-start flag for every cycle come from the bench's own byte-count model. Fetched and stored data are compared against a byte-wide memory that the responder reads and writes only through the lanes of its chosen port width.

// File: rtl/dbsz_pkg.sv
package dbsz_pkg;
  localparam int DBUS_W = 32;
  localparam int LANE_N = DBUS_W / 8;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CYC  = 2'd1,
    ST_END  = 2'd2
  } dbsz_state_t;

  localparam logic [1:0] ACK_WAIT = 2'b00;
  localparam logic [1:0] ACK_P8   = 2'b01;
  localparam logic [1:0] ACK_P16  = 2'b10;
  localparam logic [1:0] ACK_P32  = 2'b11;
endpackage

// File: rtl/dbsz_step.sv
// Bytes moved by one terminated cycle, from port width, lane offset and count owed.
module dbsz_step
  import dbsz_pkg::*;
(
  input  logic [1:0] ack,
  input  logic [1:0] ofs,
  input  logic [2:0] rem,
  output logic [2:0] moved
);
  logic [2:0] room;

  always_comb begin
    case (ack)
      ACK_P32: room = 3'd4 - {1'b0, ofs};
      ACK_P16: room = 3'd2 - {2'b00, ofs[0]};
      ACK_P8:  room = 3'd1;
      default: room = 3'd0;
    endcase
    moved = (rem < room) ? rem : room;
  end
endmodule

// File: rtl/dbsz_wr_steer.sv
// Places outgoing bytes so that 8, 16 and 32-bit devices all find theirs.
module dbsz_wr_steer
  import dbsz_pkg::*;
(
  input  logic [DBUS_W-1:0] opnd,
  input  logic [1:0]        ofs,
  output logic [DBUS_W-1:0] dout
);
  for (genvar L = 0; L < LANE_N; L++) begin : g_lane
    logic [1:0] src;
    logic [7:0] pick;
    always_comb begin
      if (L == 0)
        src = 2'd0;
      else if (L == 1)
        src = ofs[0] ? 2'd0 : 2'd1;
      else if (2'(L) >= ofs)
        src = 2'(L) - ofs;
      else
        src = 2'd0;
      case (src)
        2'd0:    pick = opnd[31:24];
        2'd1:    pick = opnd[23:16];
        2'd2:    pick = opnd[15:8];
        default: pick = opnd[7:0];
      endcase
    end
    assign dout[DBUS_W-1-8*L -: 8] = pick;
  end
endmodule

// File: rtl/dbsz_rd_merge.sv
// Collects fetched bytes from the responding port's lanes, right-justified.
module dbsz_rd_merge
  import dbsz_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              take,
  input  logic [1:0]        ack,
  input  logic [1:0]        ofs,
  input  logic [2:0]        moved,
  input  logic [DBUS_W-1:0] din,
  output logic [DBUS_W-1:0] acc
);
  logic [1:0]        first_lane;
  logic [DBUS_W-1:0] aligned;
  logic [DBUS_W-1:0] piece;

  always_comb begin
    case (ack)
      ACK_P32: first_lane = ofs;
      ACK_P16: first_lane = {1'b0, ofs[0]};
      default: first_lane = 2'd0;
    endcase
    aligned = din << {first_lane, 3'b000};
    piece   = aligned >> {(3'd4 - moved), 3'b000};
  end

  always_ff @(posedge clk) begin
    if (rst || clr)
      acc <= '0;
    else if (take)
      acc <= (acc << {moved, 3'b000}) | piece;
  end
endmodule

// File: rtl/dbsz_ctrl.sv
module dbsz_ctrl
  import dbsz_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_lock,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [2:0]        req_len,
  input  logic [31:0]       req_wdata,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [31:0]       rdata,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [1:0]        bus_siz,
  output logic              bus_rd,
  output logic              bus_ecs,
  output logic              bus_ocs,
  output logic              bus_as,
  output logic              bus_ds,
  output logic              bus_rmw,
  output logic [31:0]       bus_dout,
  output logic              bus_dout_en,
  input  logic [31:0]       bus_din,
  input  logic [1:0]        bus_ack,
  input  logic              bus_berr
);
  localparam int PAD_W = ADDR_W - 3;

  dbsz_state_t st;
  logic [2:0]        rem_q;
  logic [DBUS_W-1:0] opnd_q;
  logic              lock_q;
  logic [2:0]        moved;
  logic              start;
  logic              term;
  logic              take;

  assign start = (st == ST_IDLE) && req_valid && (req_len != 3'd0) && (req_len <= 3'd4);
  assign term  = (st == ST_CYC) && !bus_berr && (bus_ack != ACK_WAIT);
  assign take  = term && bus_rd;
  assign busy  = (st != ST_IDLE);

  dbsz_step u_step (
    .ack   (bus_ack),
    .ofs   (bus_addr[1:0]),
    .rem   (rem_q),
    .moved (moved)
  );

  dbsz_wr_steer u_wr (
    .opnd (opnd_q),
    .ofs  (bus_addr[1:0]),
    .dout (bus_dout)
  );

  dbsz_rd_merge u_rd (
    .clk   (clk),
    .rst   (rst),
    .clr   (start),
    .take  (take),
    .ack   (bus_ack),
    .ofs   (bus_addr[1:0]),
    .moved (moved),
    .din   (bus_din),
    .acc   (rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_IDLE;
      rem_q       <= '0;
      opnd_q      <= '0;
      lock_q      <= 1'b0;
      done        <= 1'b0;
      err         <= 1'b0;
      bus_addr    <= '0;
      bus_siz     <= '0;
      bus_rd      <= 1'b0;
      bus_ecs     <= 1'b0;
      bus_ocs     <= 1'b0;
      bus_as      <= 1'b0;
      bus_ds      <= 1'b0;
      bus_rmw     <= 1'b0;
      bus_dout_en <= 1'b0;
    end else begin
      done    <= 1'b0;
      err     <= 1'b0;
      bus_ecs <= 1'b0;
      bus_ocs <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (start) begin
            st          <= ST_CYC;
            rem_q       <= req_len;
            opnd_q      <= req_wdata << {(3'd4 - req_len), 3'b000};
            lock_q      <= req_lock;
            bus_addr    <= req_addr;
            bus_siz     <= req_len[1:0];
            bus_rd      <= !req_write;
            bus_ecs     <= 1'b1;
            bus_ocs     <= 1'b1;
            bus_as      <= 1'b1;
            bus_ds      <= 1'b1;
            bus_dout_en <= req_write;
            if (req_lock) bus_rmw <= 1'b1;
          end
        end
        ST_CYC: begin
          if (bus_berr) begin
            st          <= ST_IDLE;
            err         <= 1'b1;
            bus_as      <= 1'b0;
            bus_ds      <= 1'b0;
            bus_dout_en <= 1'b0;
            bus_rmw     <= 1'b0;
          end else if (term) begin
            bus_as      <= 1'b0;
            bus_ds      <= 1'b0;
            bus_dout_en <= 1'b0;
            bus_addr    <= bus_addr + {{PAD_W{1'b0}}, moved};
            rem_q       <= rem_q - moved;
            opnd_q      <= opnd_q << {moved, 3'b000};
            if (rem_q == moved) begin
              st   <= ST_IDLE;
              done <= 1'b1;
              if (lock_q && !bus_rd) bus_rmw <= 1'b0;
            end else begin
              st <= ST_END;
            end
          end
        end
        ST_END: begin
          st          <= ST_CYC;
          bus_siz     <= rem_q[1:0];
          bus_ecs     <= 1'b1;
          bus_as      <= 1'b1;
          bus_ds      <= 1'b1;
          bus_dout_en <= !bus_rd;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dbsz_chk.sv
module dbsz_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              done,
  input logic              err,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [1:0]        bus_siz,
  input logic              bus_ecs,
  input logic              bus_ocs,
  input logic              bus_as,
  input logic              bus_ds,
  input logic [1:0]        bus_ack,
  input logic              bus_berr
);
  AST_ECS_ONE_CLOCK: assert property (@(posedge clk) disable iff (rst)
    bus_ecs |=> !bus_ecs); // R3
  AST_OCS_WITH_ECS: assert property (@(posedge clk) disable iff (rst)
    bus_ocs |-> bus_ecs); // R3
  AST_ECS_WITH_STROBES: assert property (@(posedge clk) disable iff (rst)
    bus_ecs |-> (bus_as && bus_ds)); // R4
  AST_ACK_DROPS_AS: assert property (@(posedge clk) disable iff (rst)
    (bus_as && !bus_berr && bus_ack != 2'b00) |=> (!bus_as && !bus_ds)); // R4
  AST_WAIT_HOLDS_AS: assert property (@(posedge clk) disable iff (rst)
    (bus_as && !bus_berr && bus_ack == 2'b00) |=> (bus_as && !bus_ecs)); // R11
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
    (bus_as && !bus_ecs) |-> ($stable(bus_addr) && $stable(bus_siz))); // R2
  AST_BERR_ENDS: assert property (@(posedge clk) disable iff (rst)
    (bus_as && bus_berr) |=> (err && !done && !bus_as)); // R9
  AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(done && err)); // R8
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && !bus_as)); // R8
endmodule

bind dbsz_ctrl dbsz_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .busy     (busy),
  .done     (done),
  .err      (err),
  .bus_addr (bus_addr),
  .bus_siz  (bus_siz),
  .bus_ecs  (bus_ecs),
  .bus_ocs  (bus_ocs),
  .bus_as   (bus_as),
  .bus_ds   (bus_ds),
  .bus_ack  (bus_ack),
  .bus_berr (bus_berr)
);

// File: tb/sim_dbsz_ctrl.sv
`timescale 1ns/1ps
module sim_dbsz_ctrl;
  localparam logic [31:0] BASE = 32'h0000_0100;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0, req_lock = 1'b0;
  logic [31:0] req_addr = '0;
  logic [2:0]  req_len = '0;
  logic [31:0] req_wdata = '0;
  logic        busy, done, err;
  logic [31:0] rdata;
  logic [31:0] bus_addr;
  logic [1:0]  bus_siz;
  logic        bus_rd, bus_ecs, bus_ocs, bus_as, bus_ds, bus_rmw, bus_dout_en;
  logic [31:0] bus_dout;
  logic [31:0] bus_din = '0;
  logic [1:0]  bus_ack = '0;
  logic        bus_berr = 1'b0;

  always #4 clk = ~clk;

  dbsz_ctrl #(.ADDR_W(32)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_lock(req_lock), .req_addr(req_addr), .req_len(req_len),
    .req_wdata(req_wdata), .busy(busy), .done(done), .err(err), .rdata(rdata),
    .bus_addr(bus_addr), .bus_siz(bus_siz), .bus_rd(bus_rd), .bus_ecs(bus_ecs),
    .bus_ocs(bus_ocs), .bus_as(bus_as), .bus_ds(bus_ds), .bus_rmw(bus_rmw),
    .bus_dout(bus_dout), .bus_dout_en(bus_dout_en), .bus_din(bus_din),
    .bus_ack(bus_ack), .bus_berr(bus_berr)
  );

  typedef struct {
    bit          e_err;
    bit          chk_d;
    logic [31:0] d;
  } exp_t;

  exp_t        sb[$];
  logic [7:0]  mem [64];
  int          total = 0, bad = 0;
  bit          finished = 0;
  int          port_w = 4, wait_n = 0, berr_at = -1, exp_rem = 0, cyc_idx = 0;
  logic [31:0] exp_addr = '0;
  bit          exp_rd = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  function automatic logic [1:0] siz_code(input int n);
    return 2'(n & 3);
  endfunction

  function automatic int step_n(input int pw, input int a, input int rem);
    int room;
    room = (pw == 4) ? 4 - a : (pw == 2) ? 2 - (a & 1) : 1;
    return (rem < room) ? rem : room;
  endfunction

  // Responder: a device of width port_w on its lanes, backed by mem.
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && bus_ecs) begin
        int a, m, s;
        logic [31:0] din;
        check(bus_addr == exp_addr, "R5", "cycle address", bus_addr, exp_addr);
        check(bus_rd == exp_rd, "R5", "direction", 32'(bus_rd), 32'(exp_rd));
        check(bus_siz == siz_code(exp_rem), "R2", "size code", 32'(bus_siz),
              32'(siz_code(exp_rem)));
        check(bus_ocs == (cyc_idx == 0), "R3", "operand start flag",
              32'(bus_ocs), 32'(cyc_idx == 0));
        for (int w = 0; w < wait_n; w++) begin
          @(negedge clk);
          check(bus_as && bus_ds && !bus_ecs, "R11", "strobes held in wait",
                {bus_as, bus_ds, bus_ecs}, 32'b110);
        end
        a = int'(exp_addr[1:0]);
        m = step_n(port_w, a, exp_rem);
        s = (port_w == 4) ? a : (port_w == 2) ? (a & 1) : 0;
        if (cyc_idx == berr_at) begin
          bus_berr = 1'b1;
        end else begin
          din = 32'hEEEE_EEEE;
          for (int i = 0; i < m; i++) begin
            int ix;
            ix = int'((exp_addr + 32'(i)) & 32'h3F);
            din[31-8*(s+i) -: 8] = mem[ix];
            if (!bus_rd) mem[ix] = bus_dout[31-8*(s+i) -: 8];
          end
          bus_din = din;
          bus_ack = (port_w == 4) ? 2'b11 : (port_w == 2) ? 2'b10 : 2'b01;
        end
        @(negedge clk);
        check(!bus_as && !bus_ds, "R4", "strobes low after termination",
              {bus_as, bus_ds}, 32'b0);
        if (bus_berr) exp_rem = 0;
        else begin
          exp_addr = exp_addr + 32'(m);
          exp_rem  = exp_rem - m;
        end
        bus_ack  = 2'b00;
        bus_berr = 1'b0;
        bus_din  = '0;
        cyc_idx++;
      end
    end
  end

  // Monitor: pops expectations as completions appear.
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && (done || err)) begin
        exp_t e;
        if (sb.size() == 0) begin
          check(0, "R8", "unexpected completion", {done, err}, 32'b0);
        end else begin
          e = sb.pop_front();
          check(err == e.e_err, "R9", "error pulse", 32'(err), 32'(e.e_err));
          check(done == !e.e_err, "R8", "done pulse", 32'(done), 32'(!e.e_err));
          check(!busy, "R8", "busy low at completion", 32'(busy), 32'b0);
          if (e.chk_d) check(rdata == e.d, "R7", "fetched operand", rdata, e.d);
        end
      end
    end
  end

  task automatic run_op(input bit wr, input int len, input int off,
                        input logic [31:0] wd, input bit lock, input int pw,
                        input int wt, input int bc);
    logic [31:0] a, expd;
    exp_t e;
    a = BASE + 32'(off);
    expd = '0;
    for (int i = 0; i < len; i++)
      expd = (expd << 8) | 32'(mem[int'((a + 32'(i)) & 32'h3F)]);
    port_w = pw; wait_n = wt; berr_at = bc;
    exp_rem = len; exp_addr = a; exp_rd = !wr; cyc_idx = 0;
    e.e_err = (bc >= 0);
    e.chk_d = !wr && (bc < 0);
    e.d = expd;
    sb.push_back(e);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_lock = lock;
    req_addr = a; req_len = 3'(len); req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    while (!(done || err)) @(negedge clk);
    if (wr && bc < 0)
      for (int i = 0; i < len; i++)
        check(mem[int'((a + 32'(i)) & 32'h3F)] == wd[8*(len-1-i) +: 8], "R6",
              "stored byte", 32'(mem[int'((a + 32'(i)) & 32'h3F)]),
              32'(wd[8*(len-1-i) +: 8]));
    @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 8'(i) ^ 8'hA5;
    repeat (3) @(negedge clk);
    check({busy, done, err, bus_as, bus_ds, bus_ecs, bus_ocs, bus_rmw} == 8'b0,
          "R1", "outputs in reset", {busy, done, err, bus_as, bus_ds, bus_ecs,
          bus_ocs, bus_rmw}, 32'b0);
    rst = 1'b0;
    @(negedge clk);
    check({busy, done, err, bus_as, bus_ds, bus_ecs, bus_ocs, bus_rmw} == 8'b0,
          "R1", "outputs after reset", {busy, done, err, bus_as, bus_ds,
          bus_ecs, bus_ocs, bus_rmw}, 32'b0);

    run_op(1, 4, 0,  32'h1122_3344, 0, 4, 0, -1); // R5 R6 aligned 32-bit
    run_op(0, 4, 0,  32'h0,         0, 4, 0, -1); // R7 readback
    run_op(1, 4, 17, 32'hA1B2_C3D4, 0, 1, 0, -1); // R6 8-bit port, 4 cycles
    run_op(0, 4, 17, 32'h0,         0, 2, 1, -1); // R7 16-bit misaligned
    run_op(1, 3, 27, 32'h00C0_FFEE, 0, 4, 0, -1); // R5 split at word edge
    run_op(0, 2, 27, 32'h0,         0, 4, 2, -1); // R11 waits
    run_op(1, 1, 34, 32'h0000_005A, 0, 2, 0, -1); // R6 16-bit lane
    run_op(0, 3, 33, 32'h0,         0, 4, 0, -1); // R5 24-bit in one cycle
    run_op(0, 3, 35, 32'h0,         0, 1, 3, -1); // R7 8-bit with waits

    begin // R9: error on the second cycle of a byte-wide store
      logic [7:0] keep [3];
      for (int i = 0; i < 3; i++) keep[i] = mem[41 + i];
      run_op(1, 4, 40, 32'h9988_7766, 0, 1, 0, 1);
      check(mem[40] == 8'h99, "R9", "byte before error", 32'(mem[40]), 32'h99);
      for (int i = 0; i < 3; i++)
        check(mem[41 + i] == keep[i], "R9", "byte after error untouched",
              32'(mem[41 + i]), 32'(keep[i]));
      check(!bus_as && !busy, "R9", "idle after error", {bus_as, busy}, 32'b0);
    end
    run_op(0, 2, 40, 32'h0, 0, 4, 0, -1); // R9 next operand proceeds

    check(!bus_rmw, "R10", "rmw low before locked pair", 32'(bus_rmw), 32'b0);
    run_op(0, 2, 48, 32'h0, 1, 2, 0, -1);
    check(bus_rmw, "R10", "rmw held between pair", 32'(bus_rmw), 32'b1);
    run_op(1, 2, 48, 32'h0000_BEEF, 1, 2, 1, -1);
    check(!bus_rmw, "R10", "rmw low after locked store", 32'(bus_rmw), 32'b0);

    check(sb.size() == 0, "R8", "pending completions", 32'(sb.size()), 32'b0);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL R8 watchdog: actual=hung expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule